// File: doc/BRIEF.md
# Preemptive Priority-Class Interrupt Controller

This block sorts interrupt request lines into a few ordered priority classes and tracks which class the processor is running now. The lowest class, 0, stands for the main program, which runs when no interrupt is active. The top class is kept for work that cannot wait. Each request line belongs to a fixed class between 1 and `NUM_CLS-1`. A request line is recorded when it goes from low to high, and it then marks its class as pending. A pending class is offered for dispatch only when it is strictly higher than the running class. A request of the same class or a lower class waits, and it is never dropped.

When the processor accepts a dispatch, the controller pushes the running class onto a small stack of preempted levels. The accepted class then becomes the running class. When the running sequence signals that it has ended, the controller restores the level on top of the stack. On the next cycle, the pending set is scanned against that restored level. If a waiting class is higher than the restored level, it is offered before the restored code can continue. The controller does not save or restore registers and does not fetch vectors.

Top module: `prio_class_intc`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the running class is 0, `disp_valid_o` is low and no class is pending.
- R2: A low-to-high transition on request line i marks class 1 + (i*(NUM_CLS-1))/NUM_SRC as pending. A line that is held high raises its class only once. A new event from that line needs the line to go low and then high again.
- R3: `disp_valid_o` is high, and `disp_cls_o` equals the highest pending class, whenever that class is strictly above the running class.
- R4: A pending class that is equal to or below the running class keeps `disp_valid_o` low. It stays pending until a later scan offers it.
- R5: `disp_ack_i` taken while `disp_valid_o` is high has three effects on the next cycle: the running class becomes the offered class, that class is no longer pending, and the previous running class is pushed onto the stack.
- R6: `eos_i` while the running class is above 0 restores the level on top of the stack. Any pending class above that level is offered next.
- R7: Requests from several lines in the same cycle are all recorded. Their classes are then dispatched highest first.
- R8: `eos_i` while the running class is 0 has no effect.
- R9: A `disp_ack_i` given in the same cycle as an effective `eos_i` is ignored. The offer is presented again after the level is restored.
- R10: A request edge in the same cycle as `eos_i` takes part in the scan against the restored level.
- R11: A request edge for a class in the same cycle that this class is accepted leaves that class pending.
- R12: Nesting reaches the top class from class 0 through every class in between. Each `eos_i` steps back one level, and the level stack of depth `STK_DEPTH` never overflows or underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_SRC | Request lines, recorded on a low-to-high transition |
| eos_i | input | 1 | The running sequence has ended |
| disp_ack_i | input | 1 | Accepts the offered dispatch |
| disp_valid_o | output | 1 | A pending class may preempt the running class |
| disp_cls_o | output | $clog2(NUM_CLS) | Class offered for dispatch |
| run_cls_o | output | $clog2(NUM_CLS) | Class of the code now running |

## Verification
The bench uses the default build: six request lines, four classes and a four-entry level stack. With these values, each class from 1 to 3 has two lines, so two different sources of the same class can be exercised. The bench drives every line alone and checks its class mapping. It then steps through all nine ordered pairs of running class and requesting class, which covers preemption, waiting at an equal class and waiting at a lower class. The full three-level nesting is reachable, along with the edge cases where two events land in the same cycle: end with acknowledge, end with a new request, and acknowledge with a new request.

// File: rtl/pcic_pkg.sv
// Package: shared helpers for the priority-class interrupt controller.
// Assumes: at least one class above the main-program class exists.
package pcic_pkg;

    // Maps request line idx to its class, spreading the lines evenly over classes 1..ncls-1.
    function automatic int src_class(input int idx, input int nsrc, input int ncls);
        return 1 + (idx * (ncls - 1)) / nsrc;
    endfunction

endpackage

// File: rtl/pcic_pend.sv
// Module: pcic_pend
// Detects request edges and keeps one pending bit per class.
// Assumes: clr_i has at most one bit set, and only for a class being accepted.
// A set wins over a clear, so an event in the acceptance cycle is kept.
module pcic_pend #(
    parameter int NUM_SRC = 6,
    parameter int NUM_CLS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic [NUM_CLS-1:0] clr_i,
    output logic [NUM_CLS-1:0] pend_o
);

    logic [NUM_SRC-1:0] irq_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_CLS-1:0] set_v;
    logic [NUM_CLS-1:0] pend_q;

    assign rise = irq_i & ~irq_q;

    // Per class: OR together the edges of the lines that belong to it.
    for (genvar gc = 0; gc < NUM_CLS; gc++) begin : g_cls
        logic [NUM_SRC-1:0] hit;
        for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_src
            assign hit[gs] = rise[gs] && (pcic_pkg::src_class(gs, NUM_SRC, NUM_CLS) == gc);
        end
        assign set_v[gc] = |hit;
    end

    // Holds the previous level of each request line, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_i;
    end

    // Updates the pending set: accepted classes clear, new edges set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_v;
    end

    assign pend_o = pend_q;

    for (genvar gc = 0; gc < NUM_CLS; gc++) begin : g_chk
        // R2 / R7 / R11: every edge shows up as pending on the next cycle.
        a_r2_edge_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[gc] |=> pend_o[gc]);
        // R4: a pending class that is not accepted stays pending.
        a_r4_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[gc] && !clr_i[gc]) |=> pend_o[gc]);
    end

endmodule

// File: rtl/pcic_pick.sv
// Module: pcic_pick
// Priority encoder: reports the highest set class and whether any class is set.
// Assumes: a higher index means a higher priority.
module pcic_pick #(
    parameter int NUM_CLS = 4,
    localparam int CW     = $clog2(NUM_CLS)
) (
    input  logic [NUM_CLS-1:0] pend_i,
    output logic [CW-1:0]      hi_o,
    output logic               any_o
);

    // Scans from low to high so the last set bit found wins.
    always_comb begin
        hi_o  = '0;
        any_o = 1'b0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (pend_i[c]) begin
                hi_o  = CW'(c);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcic_stack.sv
// Module: pcic_stack
// Last-in first-out store for preempted class levels.
// Assumes: push and pop never arrive in the same cycle, and entries strictly rise from bottom to top.
module pcic_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o
);

    logic [W-1:0]    mem [DEPTH];
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] top_idx;

    assign top_idx = cnt_q - CNTW'(1);
    assign top_o   = (cnt_q == '0) ? '0 : mem[top_idx[AW-1:0]];

    // Tracks how many levels are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (push_i) cnt_q <= cnt_q + CNTW'(1);
        else if (pop_i)  cnt_q <= cnt_q - CNTW'(1);
    end

    // Writes a preempted level into the next free slot.
    always_ff @(posedge clk) begin
        if (push_i) mem[cnt_q[AW-1:0]] <= din_i;
    end

    // R12: the stack never overflows.
    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < CNTW'(DEPTH)));
    // R12: the stack never underflows.
    a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cnt_q != '0));
    // R12: levels are stored in strictly rising order.
    a_r12_rising_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && cnt_q != '0) |-> (din_i > top_o));
    // R9: a push and a pop never coincide.
    a_r9_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/prio_class_intc.sv
// Module: prio_class_intc (top)
// Preemptive priority-class interrupt controller. It holds the running class,
// offers a pending class only when that class is strictly higher, and keeps a
// stack of preempted levels that end-of-sequence steps back through.
// Assumes: class 0 is the main program, and request lines map to classes 1..NUM_CLS-1.
module prio_class_intc #(
    parameter int NUM_SRC   = 6,
    parameter int NUM_CLS   = 4,
    parameter int STK_DEPTH = 4,
    localparam int CW       = $clog2(NUM_CLS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               eos_i,
    input  logic               disp_ack_i,
    output logic               disp_valid_o,
    output logic [CW-1:0]      disp_cls_o,
    output logic [CW-1:0]      run_cls_o
);

    logic [CW-1:0]      run_q;
    logic [NUM_CLS-1:0] pend;
    logic [NUM_CLS-1:0] clr;
    logic [CW-1:0]      hi;
    logic               any;
    logic [CW-1:0]      stk_top;
    logic               eos_act;
    logic               take;

    pcic_pend #(.NUM_SRC(NUM_SRC), .NUM_CLS(NUM_CLS)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_i(clr), .pend_o(pend));

    pcic_pick #(.NUM_CLS(NUM_CLS)) u_pick (
        .pend_i(pend), .hi_o(hi), .any_o(any));

    pcic_stack #(.DEPTH(STK_DEPTH), .W(CW)) u_stack (
        .clk(clk), .rst_n(rst_n), .push_i(take), .pop_i(eos_act),
        .din_i(run_q), .top_o(stk_top));

    // Decides the handshake: an offer needs a strictly higher class, and an effective end blocks acceptance.
    always_comb begin
        eos_act      = eos_i && (run_q != '0);
        disp_valid_o = any && (hi > run_q);
        take         = disp_valid_o && disp_ack_i && !eos_act;
        clr          = '0;
        if (take) clr[hi] = 1'b1;
    end

    // Updates the running class on acceptance or on an end of sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (take)    run_q <= hi;
        else if (eos_act) run_q <= stk_top;
    end

    assign disp_cls_o = hi;
    assign run_cls_o  = run_q;

    // R5: an accepted offer becomes the running class.
    a_r5_accept_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_o && disp_ack_i && !eos_act) |=> (run_cls_o == $past(disp_cls_o)));
    // R6: an end of sequence always returns to a lower level.
    a_r6_eos_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        eos_act |=> (run_cls_o < $past(run_cls_o)));
    // R9: an offer that meets an effective end is still offered afterwards.
    a_r9_offer_survives_eos: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_o && eos_act) |=> disp_valid_o);
    // R8: with no end and no acceptance, the running class holds.
    a_r8_run_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!eos_i && !disp_ack_i) |=> $stable(run_cls_o));

endmodule

// File: tb/prio_class_intc_test.sv
module prio_class_intc_test;
    localparam int CLK_P = 10;
    localparam int NS    = 6;
    localparam int NC    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq = '0;
    logic          eos = 1'b0;
    logic          ack = 1'b0;
    logic          valid;
    logic [1:0]    dcls;
    logic [1:0]    run;
    int            tests = 0;
    int            fails = 0;

    prio_class_intc #(.NUM_SRC(NS), .NUM_CLS(NC), .STK_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .eos_i(eos), .disp_ack_i(ack),
        .disp_valid_o(valid), .disp_cls_o(dcls), .run_cls_o(run));

    always #(CLK_P/2) clk = ~clk;

    function automatic int cls_of(input int i);
        return 1 + (i * (NC - 1)) / NS;
    endfunction

    function automatic int src_for(input int c);
        for (int i = NS - 1; i >= 0; i--) if (cls_of(i) == c) src_for = i;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int s);
        irq[s] = 1'b1; tick(); irq[s] = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_eos();
        eos = 1'b1; tick(); eos = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 run", run, 0);
        chk("R1 valid", valid, 0);
        tick();
        chk("R1 no pending", valid, 0);

        // R8: end while in the main program is ignored
        do_eos();
        chk("R8 run", run, 0);
        chk("R8 valid", valid, 0);

        // R2: class mapping of every line
        for (int i = 0; i < NS; i++) begin
            pulse(i);
            chk("R2 valid", valid, 1);
            chk("R2 class", dcls, cls_of(i));
            do_ack();
            chk("R5 run", run, cls_of(i));
            chk("R5 cleared", valid, 0);
            do_eos();
            chk("R6 back to main", run, 0);
        end

        // R3/R4/R5/R6: every ordered pair of running and requesting class
        for (int a = 1; a < NC; a++) begin
            for (int b = 1; b < NC; b++) begin
                pulse(src_for(a));
                chk("R3 offer a", dcls, a);
                do_ack();
                chk("R5 run a", run, a);
                pulse(src_for(b));
                if (b > a) begin
                    chk("R3 preempt valid", valid, 1);
                    chk("R3 preempt class", dcls, b);
                    do_ack();
                    chk("R5 run b", run, b);
                    do_eos();
                    chk("R6 return a", run, a);
                    chk("R6 idle", valid, 0);
                    do_eos();
                    chk("R6 return main", run, 0);
                end else begin
                    chk("R4 wait", valid, 0);
                    do_eos();
                    chk("R6 return main", run, 0);
                    chk("R4 kept valid", valid, 1);
                    chk("R4 kept class", dcls, b);
                    do_ack();
                    chk("R5 run b", run, b);
                    do_eos();
                    chk("R6 return main", run, 0);
                end
                chk("R6 nothing left", valid, 0);
            end
        end

        // R7: all lines in one cycle, served highest first
        irq = '1; tick(); irq = '0;
        for (int c = NC - 1; c >= 1; c--) begin
            chk("R7 valid", valid, 1);
            chk("R7 class", dcls, c);
            do_ack();
            chk("R7 run", run, c);
            chk("R7 lower waits", valid, 0);
            do_eos();
            chk("R7 main", run, 0);
        end
        chk("R7 drained", valid, 0);

        // R9: acknowledge together with an effective end
        pulse(src_for(1)); do_ack();
        pulse(src_for(2));
        eos = 1'b1; ack = 1'b1; tick(); eos = 1'b0; ack = 1'b0;
        chk("R9 run popped", run, 0);
        chk("R9 still offered", valid, 1);
        chk("R9 class", dcls, 2);
        do_ack();
        chk("R9 run", run, 2);
        do_eos();
        chk("R9 main", run, 0);

        // R10: request edge in the same cycle as the end (lower, then equal class)
        pulse(src_for(2)); do_ack();
        irq[src_for(1)] = 1'b1; eos = 1'b1; tick(); irq = '0; eos = 1'b0;
        chk("R10 run", run, 0);
        chk("R10 offered", valid, 1);
        chk("R10 class", dcls, 1);
        do_ack(); do_eos();
        pulse(src_for(2)); do_ack();
        irq[src_for(2) + 1] = 1'b1; eos = 1'b1; tick(); irq = '0; eos = 1'b0;
        chk("R10 same class", dcls, 2);
        chk("R10 same valid", valid, 1);
        do_ack(); do_eos();
        chk("R10 main", run, 0);

        // R11: new edge of the class being accepted
        pulse(src_for(2));
        ack = 1'b1; irq[src_for(2) + 1] = 1'b1; tick(); ack = 1'b0; irq = '0;
        chk("R11 run", run, 2);
        chk("R11 equal waits", valid, 0);
        do_eos();
        chk("R11 kept", valid, 1);
        chk("R11 class", dcls, 2);
        do_ack(); do_eos();
        chk("R11 clean", valid, 0);

        // R2: a held line raises its class only once
        irq[src_for(3)] = 1'b1; tick();
        chk("R2 held offer", dcls, 3);
        do_ack(); do_eos();
        chk("R2 held no repeat", valid, 0);
        tick(); tick();
        chk("R2 held still quiet", valid, 0);
        irq = '0; tick();
        irq[src_for(3)] = 1'b1; tick();
        chk("R2 re-armed", valid, 1);
        irq = '0;
        do_ack(); do_eos();

        // R12: full nesting and step-back
        for (int c = 1; c < NC; c++) begin
            pulse(src_for(c)); do_ack();
            chk("R12 nest", run, c);
        end
        for (int c = NC - 2; c >= 0; c--) begin
            do_eos();
            chk("R12 unwind", run, c);
        end
        chk("R12 idle", valid, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule